// File: doc/BRIEF.md
# Byte-Wide Word Stack Engine

This block performs word-sized push and pop operations on a stack that lives in a byte-addressed memory. It holds a 16-bit stack pointer internally. A 16-bit stack segment value comes in on a port. Every memory address is built by shifting the segment left by four and adding a pointer-relative offset. Each command becomes two single-byte memory transfers, followed by a one-cycle completion strobe.

A push stores the high byte just below the pointer, stores the low byte below that, and then lowers the pointer by two. A pop reads the low byte at the pointer and the high byte one above it, returns the assembled word, and then raises the pointer by two. The memory port is assumed to read combinationally: read data belongs to the address shown in the same cycle. The pointer can be preset from outside while the engine is idle.

Top module: `byte_stack_engine`

## Requirements
- R1: A push drives a write of the high byte to offset SP-1 in the first cycle after acceptance. It drives a write of the low byte to offset SP-2 in the second cycle.
- R2: Once a push completes, the pointer equals its previous value minus 2, and this is visible in the done cycle.
- R3: A pop reads the low byte at offset SP in the first cycle after acceptance and the high byte at offset SP+1 in the second cycle. `pop_data_o` holds {high, low} in the done cycle and keeps it until the next pop.
- R4: Once a pop completes, the pointer equals its previous value plus 2, and this is visible in the done cycle.
- R5: The memory address equals (segment << 4) + offset, truncated to 20 bits.
- R6: All pointer and offset arithmetic wraps modulo 2^16.
- R7: `done_o` is high for exactly one cycle, the third cycle after the command is accepted. `busy_o` is high from the cycle after acceptance through the done cycle.
- R8: Push or pop requests raised while `busy_o` is high are ignored. They start no operation, do not change the stored write word, and do not alter the pointer.
- R9: When push and pop are both requested in an idle cycle, the push is performed.
- R10: `sp_load_i` copies `sp_load_val_i` into the pointer at the next edge, but only in an idle cycle with no push or pop request. In every other cycle it is ignored.
- R11: After reset the pointer is 0, `busy_o`, `done_o` and `mem_we_o` are low, and `pop_data_o` is 0.
- R12: `mem_we_o` is high only in the two transfer cycles of a push. It is low in every idle, pop and done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 16 | Word to push, taken when a push is accepted |
| seg_i | input | 16 | Stack segment value |
| sp_load_i | input | 1 | Preset the stack pointer |
| sp_load_val_i | input | 16 | Value for the pointer preset |
| mem_addr_o | output | 20 | Byte address to memory |
| mem_wdata_o | output | 8 | Byte write data |
| mem_we_o | output | 1 | Byte write enable |
| mem_rdata_i | input | 8 | Byte read data, valid for the current address |
| pop_data_o | output | 16 | Last popped word |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| sp_o | output | 16 | Current stack pointer |

## Verification
Two events can land in the same cycle. The first is a push request together with a pop request. The second is a new command, or a pointer preset, together with an operation already in flight. The bench raises push and pop in the same idle cycle and judges the result by the first-cycle write enable, the high-byte address and the final pointer. It also holds both requests with a different data word, plus a preset, across every busy cycle. That case passes only if exactly one operation happens, the original low byte is written, the pointer moves by exactly two, and the engine is idle in the cycle after done. A preset raised together with an accepted command is checked the same way.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int DEF_OFS_W     = 16;
    localparam int DEF_SEG_SHIFT = 4;
    localparam int DEF_BYTE_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI,
        ST_FIN
    } stk_state_e;

    // which offset relative to the pointer the current transfer uses
    typedef enum logic [1:0] {
        OFS_MINUS1,
        OFS_MINUS2,
        OFS_ZERO,
        OFS_PLUS1
    } ofs_sel_e;

    typedef struct packed {
        logic     we;
        logic     hi_byte;
        logic     cap_lo;
        logic     cap_hi;
        ofs_sel_e sel;
    } xfer_ctl_t;

    typedef struct packed {
        logic ld_en;
        logic step_en;
        logic step_up;
    } ptr_ctl_t;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter int OFS_W = DEF_OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ptr_ctl_t         ctl,
    input  logic [OFS_W-1:0] ld_val,
    output logic [OFS_W-1:0] sp
);
    localparam logic [OFS_W-1:0] STEP = OFS_W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (ctl.ld_en) begin
            sp <= ld_val;
        end else if (ctl.step_en) begin
            sp <= ctl.step_up ? sp + STEP : sp - STEP;
        end
    end
endmodule

// File: rtl/stk_agen.sv
module stk_agen
    import stk_pkg::*;
#(
    parameter int OFS_W     = DEF_OFS_W,
    parameter int SEG_SHIFT = DEF_SEG_SHIFT
) (
    input  logic [OFS_W-1:0]           seg,
    input  logic [OFS_W-1:0]           sp,
    input  ofs_sel_e                   sel,
    output logic [OFS_W+SEG_SHIFT-1:0] phys
);
    localparam int PHYS_W = OFS_W + SEG_SHIFT;

    logic [OFS_W-1:0]  ofs;
    logic [PHYS_W-1:0] base;

    always_comb begin
        unique case (sel)
            OFS_MINUS1: ofs = sp - OFS_W'(1);
            OFS_MINUS2: ofs = sp - OFS_W'(2);
            OFS_PLUS1:  ofs = sp + OFS_W'(1);
            default:    ofs = sp;
        endcase
    end

    assign base = {seg, {SEG_SHIFT{1'b0}}};
    assign phys = base + PHYS_W'(ofs);
endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      push_req,
    input  logic      pop_req,
    input  logic      ld_req,
    output logic      accept_push,
    output xfer_ctl_t xctl,
    output ptr_ctl_t  pctl,
    output logic      done,
    output logic      busy
);
    stk_state_e state, nxt;
    logic       idle;

    assign idle = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (push_req)     nxt = ST_PUSH_HI;
                else if (pop_req) nxt = ST_POP_LO;
            end
            ST_PUSH_HI: nxt = ST_PUSH_LO;
            ST_PUSH_LO: nxt = ST_FIN;
            ST_POP_LO:  nxt = ST_POP_HI;
            ST_POP_HI:  nxt = ST_FIN;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        xctl.we      = (state == ST_PUSH_HI) || (state == ST_PUSH_LO);
        xctl.hi_byte = (state == ST_PUSH_HI);
        xctl.cap_lo  = (state == ST_POP_LO);
        xctl.cap_hi  = (state == ST_POP_HI);
        unique case (state)
            ST_PUSH_HI: xctl.sel = OFS_MINUS1;
            ST_PUSH_LO: xctl.sel = OFS_MINUS2;
            ST_POP_HI:  xctl.sel = OFS_PLUS1;
            default:    xctl.sel = OFS_ZERO;
        endcase
    end

    assign accept_push  = idle && push_req;
    assign pctl.ld_en   = idle && ld_req && !push_req && !pop_req;
    assign pctl.step_en = (state == ST_PUSH_LO) || (state == ST_POP_HI);
    assign pctl.step_up = (state == ST_POP_HI);
    assign done         = (state == ST_FIN);
    assign busy         = !idle;
endmodule

// File: rtl/byte_stack_engine.sv
module byte_stack_engine
    import stk_pkg::*;
#(
    parameter int OFS_W     = DEF_OFS_W,
    parameter int SEG_SHIFT = DEF_SEG_SHIFT,
    parameter int BYTE_W    = DEF_BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [2*BYTE_W-1:0]        push_data_i,
    input  logic [OFS_W-1:0]           seg_i,
    input  logic                       sp_load_i,
    input  logic [OFS_W-1:0]           sp_load_val_i,
    output logic [OFS_W+SEG_SHIFT-1:0] mem_addr_o,
    output logic [BYTE_W-1:0]          mem_wdata_o,
    output logic                       mem_we_o,
    input  logic [BYTE_W-1:0]          mem_rdata_i,
    output logic [2*BYTE_W-1:0]        pop_data_o,
    output logic                       done_o,
    output logic                       busy_o,
    output logic [OFS_W-1:0]           sp_o
);
    localparam int WORD_W = 2 * BYTE_W;

    xfer_ctl_t         xctl;
    ptr_ctl_t          pctl;
    logic              accept_push;
    logic [WORD_W-1:0] push_word;

    stk_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .push_req    (push_i),
        .pop_req     (pop_i),
        .ld_req      (sp_load_i),
        .accept_push (accept_push),
        .xctl        (xctl),
        .pctl        (pctl),
        .done        (done_o),
        .busy        (busy_o)
    );

    stk_ptr #(.OFS_W(OFS_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ctl    (pctl),
        .ld_val (sp_load_val_i),
        .sp     (sp_o)
    );

    stk_agen #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_agen (
        .seg  (seg_i),
        .sp   (sp_o),
        .sel  (xctl.sel),
        .phys (mem_addr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            push_word  <= '0;
            pop_data_o <= '0;
        end else begin
            if (accept_push) push_word <= push_data_i;
            if (xctl.cap_lo) pop_data_o[BYTE_W-1:0]      <= mem_rdata_i;
            if (xctl.cap_hi) pop_data_o[WORD_W-1:BYTE_W] <= mem_rdata_i;
        end
    end

    assign mem_we_o    = xctl.we;
    assign mem_wdata_o = xctl.hi_byte ? push_word[WORD_W-1:BYTE_W] : push_word[BYTE_W-1:0];
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
    parameter int OFS_W  = 16,
    parameter int PHYS_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_we_o,
    input logic [PHYS_W-1:0] mem_addr_o,
    input logic              done_o,
    input logic              busy_o,
    input logic [OFS_W-1:0]  sp_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R7
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst) done_o |-> busy_o); // R7
    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst) $rose(mem_we_o) |=> mem_we_o); // R1
    AST_WRITE_ADJ: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o[0] != $past(mem_addr_o[0]))); // R1
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !busy_o |-> !mem_we_o); // R12
    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) done_o |-> !mem_we_o); // R12
    AST_SP_STEP_TWO: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((sp_o == OFS_W'($past(sp_o, 2) + OFS_W'(2))) ||
                    (sp_o == OFS_W'($past(sp_o, 2) - OFS_W'(2))))); // R2 R4
endmodule

bind byte_stack_engine stk_checker #(
    .OFS_W  (OFS_W),
    .PHYS_W (OFS_W + SEG_SHIFT)
) u_stk_checker (
    .clk        (clk),
    .rst        (rst),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .sp_o       (sp_o)
);

// File: tb/byte_stack_engine_bench.sv
module byte_stack_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_i, pop_i, sp_load_i;
    logic [15:0] push_data_i, seg_i, sp_load_val_i;
    logic [19:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        mem_we_o;
    logic [15:0] pop_data_o, sp_o;
    logic        done_o, busy_o;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;
    bit finished = 0;
    logic [7:0] mem [int unsigned];

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_stack_engine u_byte_stack_engine (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .push_data_i(push_data_i),
        .seg_i(seg_i), .sp_load_i(sp_load_i), .sp_load_val_i(sp_load_val_i),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
        .mem_rdata_i(mem_rdata_i), .pop_data_o(pop_data_o), .done_o(done_o),
        .busy_o(busy_o), .sp_o(sp_o)
    );

    // byte memory model with combinational read
    always @(posedge clk) begin
        if (mem_we_o) begin
            mem[32'(mem_addr_o)] = mem_wdata_o;
            wr_cnt++;
        end
    end

    always @(mem_addr_o or wr_cnt) begin
        if (mem.exists(32'(mem_addr_o))) mem_rdata_i = mem[32'(mem_addr_o)];
        else                             mem_rdata_i = 8'h00;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [19:0] a, input logic [7:0] d);
        mem[32'(a)] = d;
        wr_cnt++;
    endtask

    // preset pointer in an idle cycle and confirm
    task automatic load_sp(input logic [15:0] v);
        @(negedge clk);
        sp_load_i = 1'b1; sp_load_val_i = v;
        @(negedge clk);
        sp_load_i = 1'b0;
        chk("R10 load", sp_o, v);
    endtask

    // raise the command for one cycle; returns in the first transfer cycle
    task automatic start(input logic p, input logic q, input logic [15:0] d);
        @(negedge clk);
        push_i = p; pop_i = q; push_data_i = d;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 sp", sp_o, 0);
        chk("R11 busy", busy_o, 0);
        chk("R11 done", done_o, 0);
        chk("R11 we", mem_we_o, 0);
        chk("R11 pop_data", pop_data_o, 0);
    endtask

    task automatic t_push_basic;
        seg_i = 16'h2000;
        load_sp(16'h1000);
        start(1, 0, 16'hABCD);
        chk("R1 hi we", mem_we_o, 1);
        chk("R1 R5 hi addr", mem_addr_o, 20'h20FFF);
        chk("R1 hi byte", mem_wdata_o, 8'hAB);
        chk("R7 busy", busy_o, 1);
        chk("R7 no early done", done_o, 0);
        @(negedge clk);
        chk("R1 lo we", mem_we_o, 1);
        chk("R1 lo addr", mem_addr_o, 20'h20FFE);
        chk("R1 lo byte", mem_wdata_o, 8'hCD);
        @(negedge clk);
        chk("R7 done", done_o, 1);
        chk("R12 no we in done", mem_we_o, 0);
        chk("R2 sp", sp_o, 16'h0FFE);
        @(negedge clk);
        chk("R7 done pulse", done_o, 0);
        chk("R7 idle", busy_o, 0);
    endtask

    task automatic t_pop_basic;
        start(0, 1, 16'h0000);
        chk("R3 lo addr", mem_addr_o, 20'h20FFE);
        chk("R12 pop no we", mem_we_o, 0);
        @(negedge clk);
        chk("R3 hi addr", mem_addr_o, 20'h20FFF);
        chk("R12 pop no we", mem_we_o, 0);
        @(negedge clk);
        chk("R3 word", pop_data_o, 16'hABCD);
        chk("R4 sp", sp_o, 16'h1000);
        chk("R7 done", done_o, 1);
        @(negedge clk);
        chk("R3 hold", pop_data_o, 16'hABCD);
    endtask

    task automatic t_ptr_wrap;
        seg_i = 16'h0100;
        load_sp(16'h0000);
        start(1, 0, 16'h1234);
        chk("R6 hi addr", mem_addr_o, 20'h10FFF);
        @(negedge clk);
        chk("R6 lo addr", mem_addr_o, 20'h10FFE);
        @(negedge clk);
        chk("R6 sp", sp_o, 16'hFFFE);
        start(0, 1, 16'h0000);
        @(negedge clk);
        @(negedge clk);
        chk("R6 word", pop_data_o, 16'h1234);
        chk("R6 sp back", sp_o, 16'h0000);
    endtask

    task automatic t_pop_wrap;
        seg_i = 16'h0300;
        preload(20'h12FFF, 8'h5A);
        preload(20'h03000, 8'hC3);
        load_sp(16'hFFFF);
        start(0, 1, 16'h0000);
        chk("R6 R3 lo addr", mem_addr_o, 20'h12FFF);
        @(negedge clk);
        chk("R6 R3 hi addr", mem_addr_o, 20'h03000);
        @(negedge clk);
        chk("R3 word", pop_data_o, 16'hC35A);
        chk("R6 R4 sp", sp_o, 16'h0001);
    endtask

    task automatic t_seg_wrap;
        seg_i = 16'hFFFF;
        load_sp(16'h0020);
        start(1, 0, 16'h7788);
        chk("R5 hi addr", mem_addr_o, 20'h0000F);
        @(negedge clk);
        chk("R5 lo addr", mem_addr_o, 20'h0000E);
        @(negedge clk);
    endtask

    task automatic t_busy_ignore;
        seg_i = 16'h2000;
        load_sp(16'h1000);
        start(1, 0, 16'h1111);
        push_i = 1; pop_i = 1; push_data_i = 16'h2222;
        sp_load_i = 1; sp_load_val_i = 16'h5555;
        @(negedge clk);
        chk("R8 lo byte kept", mem_wdata_o, 8'h11);
        chk("R8 lo addr", mem_addr_o, 20'h20FFE);
        @(negedge clk);
        push_i = 0; pop_i = 0; sp_load_i = 0;
        chk("R8 R10 sp", sp_o, 16'h0FFE);
        chk("R7 done", done_o, 1);
        @(negedge clk);
        chk("R8 no second op", busy_o, 0);
        chk("R8 no write", mem_we_o, 0);
        chk("R8 sp stable", sp_o, 16'h0FFE);
    endtask

    task automatic t_both;
        @(negedge clk);
        push_i = 1; pop_i = 1; push_data_i = 16'h3344;
        sp_load_i = 1; sp_load_val_i = 16'h5555;
        @(negedge clk);
        push_i = 0; pop_i = 0; sp_load_i = 0;
        chk("R9 push wins we", mem_we_o, 1);
        chk("R9 hi addr", mem_addr_o, 20'h20FFD);
        chk("R9 hi byte", mem_wdata_o, 8'h33);
        @(negedge clk);
        @(negedge clk);
        chk("R9 R10 sp", sp_o, 16'h0FFC);
        @(negedge clk);
    endtask

    initial begin
        rst = 1; push_i = 0; pop_i = 0; sp_load_i = 0;
        push_data_i = 0; seg_i = 0; sp_load_val_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_push_basic();
        t_pop_basic();
        t_ptr_wrap();
        t_pop_wrap();
        t_seg_wrap();
        t_busy_ignore();
        t_both();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule